// File: doc/BRIEF.md
# Stack-Machine Operand Address Generator

This unit computes the operand address for memory-reference instructions of a 16-bit stack-architecture processor. A decoded instruction supplies a base selector (program counter, data base, frame marker or stack top), a signed displacement and two flags: one for indirect and one for indexed addressing. The current values of the four base registers and the index register come in alongside. On a start strobe the unit produces the final effective address together with a one-cycle done pulse.

Direct addressing finishes without touching memory. Indirect addressing first locates a pointer cell at base plus displacement and fetches it with one read over a simple request/valid handshake. The way the fetched word is read depends on the segment. In the code segment it is a signed offset from the cell's own address. In the data segment it is always an offset from the data base, whichever base was used to find the cell. When indexing is also requested, the index register is added after the indirect step has been resolved.

Top module: `ea_unit`

## Requirements
- R1: In direct mode (`ind`=0, `idx`=0), `ea` equals the selected base plus the sign-extended displacement, modulo 2^16. The selector encoding is 0=P, 1=DB, 2=Q, 3=S. The displacement is two's complement, so both positive and negative offsets work, and the sum wraps past 0xFFFF.
- R2: In direct mode with `idx`=1, `reg_x` is added as well. This holds for positive and negative displacements and for every base.
- R3: With `ind`=1 and selector P, the read address is P plus the sign-extended displacement, and `ea` is that cell address plus the fetched word taken as a signed 16-bit value.
- R4: With `ind`=1 and selector DB, Q or S, the read address is base plus the sign-extended displacement, and `ea` is `reg_db` plus the fetched word, regardless of which base located the cell.
- R5: A data-segment indirect result may lie below the cell's address as well as above it. A negative fetched word gives an address below DB.
- R6: With `ind`=1 and `idx`=1, the read address does not include `reg_x`. `reg_x` is added to the address resolved from the fetched word.
- R7: A direct request raises `done` with a valid `ea` on the cycle after `start` and raises no `mem_req`.
- R8: An indirect request raises `mem_req` for exactly one cycle, on the cycle after `start`, with `mem_addr` set to the cell address. `done` rises on the cycle after `mem_rvalid`.
- R9: A `start` that arrives while an indirect read is outstanding is ignored. It produces no further `done` or `mem_req`, and it does not change the pending result.
- R10: While `rst` is high and after it falls, `done` and `mem_req` are 0 and `ea` is 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address calculation |
| base_sel | input | 2 | Base selector: 0=P, 1=DB, 2=Q, 3=S |
| disp | input | DISP_W | Signed displacement |
| ind | input | 1 | Indirect addressing flag |
| idx | input | 1 | Indexed addressing flag |
| reg_p | input | ADDR_W | Program counter value |
| reg_db | input | ADDR_W | Data base register |
| reg_q | input | ADDR_W | Frame marker register |
| reg_s | input | ADDR_W | Stack top register |
| reg_x | input | ADDR_W | Index register |
| mem_req | output | 1 | One-cycle read request for the pointer cell |
| mem_addr | output | ADDR_W | Address of the pointer cell |
| mem_rdata | input | ADDR_W | Fetched pointer word |
| mem_rvalid | input | 1 | Fetched word valid |
| done | output | 1 | Result valid pulse |
| ea | output | ADDR_W | Effective address |

## Verification
The assertions watch the control timing on every cycle. They check that a direct request completes one cycle later with no read, that an indirect request issues a single one-cycle read, that done follows read-valid by one cycle, that nothing completes while a read is outstanding, and that reset leaves the outputs quiet. The address values themselves come from the bench's scenarios. These cover each base with positive, negative and wrapping displacements, code-relative and data-base-relative pointer cells, pointers that land below the cell, the ordering of indexing after indirection, and a second start arriving while a read is pending.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SEL_P  = 2'd0,
    SEL_DB = 2'd1,
    SEL_Q  = 2'd2,
    SEL_S  = 2'd3
  } base_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_locate.sv
module ea_locate
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [1:0]        base_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic              idx,
  input  logic [ADDR_W-1:0] reg_p,
  input  logic [ADDR_W-1:0] reg_db,
  input  logic [ADDR_W-1:0] reg_q,
  input  logic [ADDR_W-1:0] reg_s,
  input  logic [ADDR_W-1:0] reg_x,
  output logic              code_seg,
  output logic [ADDR_W-1:0] cell_addr,
  output logic [ADDR_W-1:0] direct_ea
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_val;

  generate
    if (DISP_W < ADDR_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (base_sel_e'(base_sel))
      SEL_P:   base_val = reg_p;
      SEL_DB:  base_val = reg_db;
      SEL_Q:   base_val = reg_q;
      default: base_val = reg_s;
    endcase
  end

  assign code_seg  = (base_sel_e'(base_sel) == SEL_P);
  assign cell_addr = base_val + disp_ext;
  assign direct_ea = cell_addr + (idx ? reg_x : '0);
endmodule

// File: rtl/ea_resolve.sv
module ea_resolve #(
  parameter int ADDR_W = 16
) (
  input  logic              code_seg,
  input  logic              idx,
  input  logic [ADDR_W-1:0] cell_addr,
  input  logic [ADDR_W-1:0] db_val,
  input  logic [ADDR_W-1:0] x_val,
  input  logic [ADDR_W-1:0] word,
  output logic [ADDR_W-1:0] resolved_ea
);
  logic [ADDR_W-1:0] anchor;
  logic [ADDR_W-1:0] pointed;

  // Code cells are self-relative; data cells always hang off DB.
  assign anchor      = code_seg ? cell_addr : db_val;
  assign pointed     = anchor + word;
  assign resolved_ea = pointed + (idx ? x_val : '0);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ind,
  input  logic              idx,
  input  logic              code_seg,
  input  logic [ADDR_W-1:0] reg_db,
  input  logic [ADDR_W-1:0] reg_x,
  input  logic [ADDR_W-1:0] cell_addr,
  input  logic [ADDR_W-1:0] direct_ea,
  input  logic [ADDR_W-1:0] resolved_ea,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              code_q,
  output logic              idx_q,
  output logic [ADDR_W-1:0] db_q,
  output logic [ADDR_W-1:0] x_q,
  output logic              done,
  output logic [ADDR_W-1:0] ea
);
  ea_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      ea       <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      code_q   <= 1'b0;
      idx_q    <= 1'b0;
      db_q     <= '0;
      x_q      <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (ind) begin
              state    <= ST_REQ;
              mem_req  <= 1'b1;
              mem_addr <= cell_addr;
              code_q   <= code_seg;
              idx_q    <= idx;
              db_q     <= reg_db;
              x_q      <= reg_x;
            end else begin
              ea   <= direct_ea;
              done <= 1'b1;
            end
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            ea    <= resolved_ea;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DIRECT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !ind) |=> (done && !mem_req)); // R7
  AST_INDIRECT_ISSUES_READ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && ind) |=> (mem_req && !done)); // R8
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R8
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && mem_rvalid) |=> done); // R8
  AST_QUIET_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !mem_rvalid) |=> (!done && !mem_req)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done && !mem_req && ea == '0)); // R10
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        base_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic              ind,
  input  logic              idx,
  input  logic [ADDR_W-1:0] reg_p,
  input  logic [ADDR_W-1:0] reg_db,
  input  logic [ADDR_W-1:0] reg_q,
  input  logic [ADDR_W-1:0] reg_s,
  input  logic [ADDR_W-1:0] reg_x,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              done,
  output logic [ADDR_W-1:0] ea
);
  logic              code_seg;
  logic [ADDR_W-1:0] cell_addr;
  logic [ADDR_W-1:0] direct_ea;
  logic [ADDR_W-1:0] resolved_ea;
  logic              code_q;
  logic              idx_q;
  logic [ADDR_W-1:0] db_q;
  logic [ADDR_W-1:0] x_q;

  ea_locate #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_locate (
    .base_sel (base_sel),
    .disp     (disp),
    .idx      (idx),
    .reg_p    (reg_p),
    .reg_db   (reg_db),
    .reg_q    (reg_q),
    .reg_s    (reg_s),
    .reg_x    (reg_x),
    .code_seg (code_seg),
    .cell_addr(cell_addr),
    .direct_ea(direct_ea)
  );

  ea_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .code_seg   (code_q),
    .idx        (idx_q),
    .cell_addr  (mem_addr),
    .db_val     (db_q),
    .x_val      (x_q),
    .word       (mem_rdata),
    .resolved_ea(resolved_ea)
  );

  ea_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ind        (ind),
    .idx        (idx),
    .code_seg   (code_seg),
    .reg_db     (reg_db),
    .reg_x      (reg_x),
    .cell_addr  (cell_addr),
    .direct_ea  (direct_ea),
    .resolved_ea(resolved_ea),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .code_q     (code_q),
    .idx_q      (idx_q),
    .db_q       (db_q),
    .x_q        (x_q),
    .done       (done),
    .ea         (ea)
  );
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    base_sel = '0;
  logic [DW-1:0] disp = '0;
  logic          ind = 1'b0;
  logic          idx = 1'b0;
  logic [AW-1:0] reg_p = 16'h1000, reg_db = 16'h2000, reg_q = 16'h2400,
                 reg_s = 16'h2800, reg_x = 16'h0005;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] mem_rdata = '0;
  logic          mem_rvalid = 1'b0;
  logic          done;
  logic [AW-1:0] ea;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int lat_cnt = 0;
  logic [AW-1:0] cell_val = '0;
  logic [AW-1:0] exp_ea[$];
  string         exp_tag[$];

  always #2 clk = ~clk;

  ea_unit #(.ADDR_W(AW), .DISP_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_sel(base_sel), .disp(disp),
    .ind(ind), .idx(idx), .reg_p(reg_p), .reg_db(reg_db), .reg_q(reg_q),
    .reg_s(reg_s), .reg_x(reg_x), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .done(done), .ea(ea)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model: answers each request LAT cycles later with cell_val.
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      lat_cnt    <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        req_cnt <= req_cnt + 1;
        lat_cnt <= LAT;
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= cell_val;
        end
      end
    end
  end

  // Monitor: every done pops one expected address from the scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_ea.size() == 0) begin
        chk(1'b0, "R9 unexpected done", ea, '0);
      end else begin
        automatic logic [AW-1:0] e = exp_ea.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(ea == e, t, ea, e);
      end
    end
  end

  task automatic run_op(input logic [1:0] b, input logic [DW-1:0] d,
                        input bit ind_i, input bit idx_i,
                        input logic [AW-1:0] cval, input logic [AW-1:0] cell_exp,
                        input logic [AW-1:0] ea_exp, input string tag,
                        input bit ghost);
    int reqs_before;
    @(negedge clk);
    cell_val = cval;
    exp_ea.push_back(ea_exp);
    exp_tag.push_back(tag);
    reqs_before = req_cnt;
    start = 1'b1; base_sel = b; disp = d; ind = ind_i; idx = idx_i;
    @(negedge clk);
    start = 1'b0;
    if (!ind_i) begin
      chk(done && !mem_req, "R7 direct done next cycle", {15'd0, done}, 16'd1);
    end else begin
      chk(mem_req == 1'b1, "R8 read issued", {15'd0, mem_req}, 16'd1);
      chk(mem_addr == cell_exp, {tag, " cell address"}, mem_addr, cell_exp);
      forever begin
        @(negedge clk);
        if (mem_rvalid) break;
        if (ghost) begin
          start = 1'b1; base_sel = 2'd0; disp = 8'h10; ind = 1'b0; idx = 1'b0;
        end
      end
      start = 1'b0;
      chk(!done, "R8 no done before valid taken", {15'd0, done}, 16'd0);
      @(negedge clk);
      chk(done == 1'b1, "R8 done after valid", {15'd0, done}, 16'd1);
      chk(req_cnt - reqs_before == 1, "R8 exactly one read",
          AW'(req_cnt - reqs_before), 16'd1);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && ea == 16'h0, "R10 in reset", ea, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_req && ea == 16'h0, "R10 after reset", ea, 16'h0);

    // R1 direct, each base, both signs
    run_op(2'd0, 8'h04, 0, 0, 0, 0, 16'h1004, "R1 P+4", 0);
    run_op(2'd0, 8'hFC, 0, 0, 0, 0, 16'h0FFC, "R1 P-4", 0);
    run_op(2'd1, 8'h04, 0, 0, 0, 0, 16'h2004, "R1 DB+4", 0);
    run_op(2'd2, 8'hFC, 0, 0, 0, 0, 16'h23FC, "R1 Q-4", 0);
    run_op(2'd3, 8'hFC, 0, 0, 0, 0, 16'h27FC, "R1 S-4", 0);
    reg_p = 16'hFFFE;
    run_op(2'd0, 8'h04, 0, 0, 0, 0, 16'h0002, "R1 wrap", 0);
    reg_p = 16'h1000;
    // R2 direct indexed
    run_op(2'd0, 8'h04, 0, 1, 0, 0, 16'h1009, "R2 P+4,X", 0);
    run_op(2'd2, 8'hFC, 0, 1, 0, 0, 16'h2401, "R2 Q-4,X", 0);
    // R3 code indirect, self-relative
    run_op(2'd0, 8'h04, 1, 0, 16'h0003, 16'h1004, 16'h1007, "R3 P+4,I", 0);
    run_op(2'd0, 8'hFC, 1, 0, 16'hFFFD, 16'h0FFC, 16'h0FF9, "R3 P-4,I", 0);
    // R4 data indirect, always DB-relative
    run_op(2'd1, 8'h04, 1, 0, 16'h0007, 16'h2004, 16'h2007, "R4 DB+4,I", 0);
    run_op(2'd2, 8'h04, 1, 0, 16'h0007, 16'h2404, 16'h2007, "R4 Q+4,I", 0);
    run_op(2'd3, 8'hFC, 1, 0, 16'h0007, 16'h27FC, 16'h2007, "R4 S-4,I", 0);
    run_op(2'd2, 8'hFC, 1, 0, 16'h0007, 16'h23FC, 16'h2007, "R4 Q-4,I", 0);
    // R5 result below the cell
    run_op(2'd1, 8'h04, 1, 0, 16'hFFF0, 16'h2004, 16'h1FF0, "R5 negative word", 0);
    // R6 index applied after indirection
    run_op(2'd1, 8'h04, 1, 1, 16'h0007, 16'h2004, 16'h200C, "R6 DB+4,I,X", 0);
    run_op(2'd0, 8'h04, 1, 1, 16'h0003, 16'h1004, 16'h100C, "R6 P+4,I,X", 0);
    // R9 start during pending read is ignored
    run_op(2'd2, 8'h04, 1, 0, 16'h0009, 16'h2404, 16'h2009, "R9 pending result", 1);

    chk(exp_ea.size() == 0, "R9 scoreboard drained", AW'(exp_ea.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule